// File: doc/BRIEF.md
# Nested Page-Table Walker

This block turns a 32-bit virtual address into a physical address for a machine whose memory is split into a user region and a system region. The system page table sits at a fixed physical base. The user page table is placed in system virtual space, so its base is itself a virtual address. A user translation therefore needs a second, inner translation to find where its own page-table entry physically lives.

A client presents an address on `req_valid`/`req_vaddr`. The walker then issues word reads over a single-outstanding request/acknowledge memory port. It finishes with a one-cycle `done` pulse. With the pulse it gives either the physical address or a fault with a code that says where the walk stopped. Pages are 512 bytes. Entries are 4 bytes, with the valid flag in bit 31 and the frame number in bits 20:0.

Top module: `pt_walker`

## Requirements
- R1: After reset, `done`, `fault` and `mem_req` are low.
- R2: A system-region request (address bits 31:30 = 2'b10) makes exactly one read, at `sys_base + vpn*4`, where vpn is address bits 29:9. If entry bit 31 is set, the result is `paddr = {entry[20:0], addr[8:0]}` with `fault` low.
- R3: A user-region request (bits 31:30 = 2'b00) forms `pte_va = user_base + vpn*4`. It then reads the system entry at `sys_base + pte_va[29:9]*4`. Next it reads the user entry at physical address `{sys_entry[20:0], pte_va[8:0]}`. It returns `paddr = {user_entry[20:0], addr[8:0]}`, using exactly two reads.
- R4: A request with bits 31:30 equal to 2'b01 or 2'b11 ends with `fault` high and `fault_code` = 0 (illegal region). No memory read is made.
- R5: A system entry with bit 31 clear ends the walk with `fault_code` = 1. This holds on both the system and the user path, and no further read is made.
- R6: A user entry with bit 31 clear ends the walk with `fault_code` = 2 after exactly two reads.
- R7: If `pte_va` for a user request does not lie in system space (bits 31:30 not 2'b10), the walk faults with `fault_code` = 0 and makes no read.
- R8: Once raised, `mem_req` stays high with `mem_addr` unchanged until `mem_ack` is seen. At most one read is outstanding.
- R9: `done` is high for exactly one cycle per accepted request. A `req_valid` during a walk is ignored: it does not change the result and does not start another walk.
- R10: Entry bits 30:21 (modify, access-control and spare) have no effect on the addresses produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| user_base | input | 32 | User page-table base, a system virtual address |
| sys_base | input | 32 | System page-table base, a physical address |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Byte address of the word read |
| mem_ack | input | 1 | Read completes; `mem_rdata` valid this cycle |
| mem_rdata | input | 32 | Read data (page-table entry) |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault (valid with `done`) |
| fault_code | output | 2 | 0 illegal region, 1 system entry invalid, 2 user entry invalid |
| paddr | output | 30 | Physical address (valid with `done` when `fault` is low) |

## Verification
The hardest case to reach from the ports is a user walk whose inner system lookup succeeds but whose final user entry is invalid. It is equally hard to show that a user-region request never reads memory when its entry address leaves system space. The bench builds a small sparse memory model. It plants a valid system entry and leaves the matching user entry absent. It also points `user_base` into the user region, and then checks both the fault code and the logged read count and addresses. Varying the acknowledge latency keeps the request held across several cycles. In that window the bench injects a second request to confirm it is ignored.

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker #(
  parameter int VA_W      = 32,
  parameter int OFF_W     = 9,
  parameter int FRAME_W   = 21,
  parameter int VALID_BIT = 31
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic [VA_W-1:0]          user_base,
  input  logic [VA_W-1:0]          sys_base,
  output logic                     mem_req,
  output logic [VA_W-1:0]          mem_addr,
  input  logic                     mem_ack,
  input  logic [VA_W-1:0]          mem_rdata,
  output logic                     done,
  output logic                     fault,
  output logic [1:0]               fault_code,
  output logic [FRAME_W+OFF_W-1:0] paddr
);
  localparam int VPN_W = VA_W - 2 - OFF_W;
  localparam int PA_W  = FRAME_W + OFF_W;
  localparam int PAD_W = VA_W - VPN_W - 2;
  localparam logic [1:0] RGN_USER = 2'b00;
  localparam logic [1:0] RGN_SYS  = 2'b10;
  localparam logic [1:0] FC_ILLEGAL = 2'd0;
  localparam logic [1:0] FC_SYS_INV = 2'd1;
  localparam logic [1:0] FC_USR_INV = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_SYS, S_USR, S_DONE, S_FAULT} state_t;

  state_t             state;
  logic [VA_W-1:0]    addr_q;
  logic [OFF_W-1:0]   va_off_q, pte_off_q;
  logic               last_q;
  logic [PA_W-1:0]    paddr_q;
  logic [1:0]         code_q;

  wire [1:0]         region    = req_vaddr[VA_W-1 -: 2];
  wire [VPN_W-1:0]   req_vpn   = req_vaddr[VA_W-3:OFF_W];
  wire [VA_W-1:0]    upte_va   = user_base + {{PAD_W{1'b0}}, req_vpn, 2'b00};
  wire [VPN_W-1:0]   upte_vpn  = upte_va[VA_W-3:OFF_W];
  wire [VA_W-1:0]    sys_pte_d = sys_base + {{PAD_W{1'b0}}, req_vpn, 2'b00};
  wire [VA_W-1:0]    sys_pte_u = sys_base + {{PAD_W{1'b0}}, upte_vpn, 2'b00};
  wire               pte_ok    = mem_rdata[VALID_BIT];
  wire [FRAME_W-1:0] frame     = mem_rdata[FRAME_W-1:0];
  wire               unused_rdata = &{1'b0, mem_rdata[VALID_BIT-1:FRAME_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      addr_q    <= '0;
      va_off_q  <= '0;
      pte_off_q <= '0;
      last_q    <= 1'b0;
      paddr_q   <= '0;
      code_q    <= FC_ILLEGAL;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_off_q <= req_vaddr[OFF_W-1:0];
          if (region == RGN_SYS) begin
            addr_q <= sys_pte_d;
            last_q <= 1'b1;
            state  <= S_SYS;
          end else if (region == RGN_USER && upte_va[VA_W-1 -: 2] == RGN_SYS) begin
            addr_q    <= sys_pte_u;
            pte_off_q <= upte_va[OFF_W-1:0];
            last_q    <= 1'b0;
            state     <= S_SYS;
          end else begin
            code_q <= FC_ILLEGAL;
            state  <= S_FAULT;
          end
        end
        S_SYS: if (mem_ack) begin
          if (!pte_ok) begin
            code_q <= FC_SYS_INV;
            state  <= S_FAULT;
          end else if (last_q) begin
            paddr_q <= {frame, va_off_q};
            state   <= S_DONE;
          end else begin
            addr_q <= {{(VA_W-PA_W){1'b0}}, frame, pte_off_q};
            state  <= S_USR;
          end
        end
        S_USR: if (mem_ack) begin
          if (!pte_ok) begin
            code_q <= FC_USR_INV;
            state  <= S_FAULT;
          end else begin
            paddr_q <= {frame, va_off_q};
            state   <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_req    = (state == S_SYS) || (state == S_USR);
  assign mem_addr   = addr_q;
  assign done       = (state == S_DONE) || (state == S_FAULT);
  assign fault      = (state == S_FAULT);
  assign fault_code = code_q;
  assign paddr      = paddr_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_ILLEGAL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && !done && req_valid && req_vaddr[VA_W-2])
      |=> fault && !mem_req && fault_code == FC_ILLEGAL); // R4
  AST_SYS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SYS && mem_ack && !mem_rdata[VALID_BIT])
      |=> fault && fault_code == FC_SYS_INV && !mem_req); // R5
  AST_USR_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_USR && mem_ack && !mem_rdata[VALID_BIT])
      |=> fault && fault_code == FC_USR_INV); // R6
endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0;
  logic [31:0] req_vaddr = '0, user_base = '0, sys_base = '0;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic        done, fault;
  logic [1:0]  fault_code;
  logic [29:0] paddr;

  int checks = 0, errors = 0;
  int lat = 0;
  int rd_cnt = 0;
  logic [31:0] rd_log [64];
  logic [31:0] tab_a [16];
  logic [31:0] tab_d [16];
  int tab_n = 0;
  logic [3:0] wcnt;

  always #4 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .user_base(user_base), .sys_base(sys_base), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .fault_code(fault_code), .paddr(paddr));

  function automatic logic [31:0] lookup(input logic [31:0] a);
    for (int i = 0; i < 16; i++)
      if (i < tab_n && tab_a[i] == a) return tab_d[i];
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; wcnt <= '0; mem_rdata <= '0;
    end else if (!mem_req || mem_ack) begin
      mem_ack <= 1'b0; wcnt <= '0;
    end else if (int'(wcnt) == lat) begin
      mem_ack <= 1'b1;
      mem_rdata <= lookup(mem_addr);
      rd_log[rd_cnt[5:0]] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end else wcnt <= wcnt + 1'b1;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    tab_a[tab_n] = a; tab_d[tab_n] = d; tab_n++;
  endtask

  function automatic logic [31:0] pte_at(input logic [31:0] base, input logic [31:0] va);
    return base + {9'd0, va[29:9], 2'b00};
  endfunction

  // runs one request; returns with outputs sampled in the done cycle
  task automatic walk(input logic [31:0] va, input string rq, input bit exp_fault,
                      input logic [1:0] exp_code, input logic [29:0] exp_pa,
                      input int exp_reads, input logic [31:0] a0, input logic [31:0] a1,
                      input bit inject);
    int base = rd_cnt;
    int n = 0;
    @(negedge clk);
    req_valid = 1; req_vaddr = va;
    @(negedge clk);
    req_valid = 0;
    while (!done && n < 100) begin
      if (inject && n == 1) begin req_valid = 1; req_vaddr = 32'h4000_0000; end
      else req_valid = 0;
      @(negedge clk); n++;
    end
    req_valid = 0;
    chk(done, rq, "done seen", {31'd0, done}, 32'd1);
    chk(fault == exp_fault, rq, "fault", {31'd0, fault}, {31'd0, exp_fault});
    if (exp_fault) chk(fault_code == exp_code, rq, "fault_code", {30'd0, fault_code}, {30'd0, exp_code});
    else chk(paddr == exp_pa, rq, "paddr", {2'd0, paddr}, {2'd0, exp_pa});
    chk(rd_cnt - base == exp_reads, rq, "read count", rd_cnt - base, exp_reads);
    if (exp_reads > 0) chk(rd_log[base[5:0]] == a0, rq, "first read addr", rd_log[base[5:0]], a0);
    if (exp_reads > 1) chk(rd_log[base[5:0]+6'd1] == a1, rq, "second read addr", rd_log[base[5:0]+6'd1], a1);
    @(negedge clk);
    chk(!done, "R9", "done one cycle", {31'd0, done}, 32'd0);
    for (int k = 0; k < 3; k++) @(negedge clk);
    chk(!done && !mem_req && rd_cnt - base == exp_reads, "R9", "no extra walk",
        rd_cnt - base, exp_reads);
  endtask

  logic [31:0] u_va, u_pva, s_pa, u_pa;

  task automatic t_reset;
    chk(!done && !fault && !mem_req, "R1", "reset outputs", {29'd0, done, fault, mem_req}, 32'd0);
  endtask

  task automatic t_system;
    logic [31:0] va = 32'h8000_0A10;
    lat = 0;
    walk(va, "R2", 0, 0, {21'h777, va[8:0]}, 1, pte_at(sys_base, va), 0, 0);
    lat = 2;
    walk(32'h8000_0C00, "R5", 1, 2'd1, 0, 1, pte_at(sys_base, 32'h8000_0C00), 0, 0);
  endtask

  task automatic t_user;
    lat = 1;
    // user entry carries modify/access bits 30:29 set: R10
    walk(u_va, "R3", 0, 0, {21'h0ABC, u_va[8:0]}, 2, s_pa, u_pa, 0);
    chk(paddr[29:9] == 21'h0ABC, "R10", "frame ignores flag bits", {11'd0, paddr[29:9]}, 32'h0ABC);
  endtask

  task automatic t_busy;
    lat = 3;
    walk(u_va, "R8", 0, 0, {21'h0ABC, u_va[8:0]}, 2, s_pa, u_pa, 1);
  endtask

  task automatic t_user_faults;
    logic [31:0] va2 = 32'h0000_0200;
    logic [31:0] pv2 = pte_at(user_base, va2);
    lat = 0;
    walk(va2, "R6", 1, 2'd2, 0, 2, pte_at(sys_base, pv2), {2'd0, 21'h123, pv2[8:0]}, 0);
    user_base = 32'h8000_6000;
    walk(u_va, "R5", 1, 2'd1, 0, 1, pte_at(sys_base, pte_at(user_base, u_va)), 0, 0);
    user_base = 32'h0000_4000;
    walk(u_va, "R7", 1, 2'd0, 0, 0, 0, 0, 0);
    user_base = 32'h8000_4000;
  endtask

  task automatic t_illegal;
    walk(32'h4000_0100, "R4", 1, 2'd0, 0, 0, 0, 0, 0);
    walk(32'hC000_0100, "R4", 1, 2'd0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    sys_base  = 32'h0010_0000;
    user_base = 32'h8000_4000;
    u_va  = 32'h0000_1A37;
    u_pva = pte_at(user_base, u_va);
    s_pa  = pte_at(sys_base, u_pva);
    u_pa  = {2'd0, 21'h123, u_pva[8:0]};
    put(pte_at(sys_base, 32'h8000_0A10), 32'h8000_0777);
    put(s_pa, 32'h8000_0123);
    put(u_pa, 32'hE000_0ABC);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_system();
    t_user();
    t_busy();
    t_user_faults();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule